// File: doc/BRIEF.md
# Serial Interrupt Slot Driver

This block is the peripheral end of a shared, open-drain serial interrupt line. A pull-up holds the line high when nobody drives it. The host opens a cycle with a Start Frame, a low pulse several clocks long. Data frames of three clocks each follow. The block counts those frames and acts only in the one that matches its configured slot number. There it reports the local interrupt request with the polarity configured for that slot. It then pulls the line back high for one clock and releases it.

After the last data frame, the host sends a short low pulse, the Stop Frame. Its width selects the bus mode for the next cycle. The block measures that width and remembers the mode. In quiet mode, the block may open a new cycle itself when its request no longer matches the value it last reported. To do so it pulls the line low for a single clock, and the host then stretches that pulse into a full Start Frame. In continuous mode, only the host opens cycles.

The block drives the line through an enable and a value: the pad drives `drv_val` while `drv_en` is high and floats otherwise. The line is read back on `line_in`, which is synchronous to `clk`.

Top module: `serirq_slot`

## Requirements
- R1: Out of reset, the block is in continuous mode and `drv_en` is low. A request that differs from the reset reported value (0) does not make it drive.
- R2: A Start Frame is a low level on `line_in` lasting at least START_MIN clocks. Call the first clock in which the line is seen high after it clock 0. The sample, recovery and turn-around phases of data frame n then occupy clocks 1+3n, 2+3n and 3+3n. The block drives only in the frame equal to `slot_sel`, and a `slot_sel` of NUM_FRAMES or more never drives.
- R3: With `slot_act_low`=0 (active-high slot), the block drives low (`drv_en`=1, `drv_val`=0) in its sample phase when `irq_req`=0, and leaves `drv_en`=0 when `irq_req`=1.
- R4: With `slot_act_low`=1 (active-low slot), the block drives low in its sample phase when `irq_req`=1, and leaves `drv_en`=0 when `irq_req`=0.
- R5: In its recovery phase, the block drives high (`drv_en`=1, `drv_val`=1) exactly when it drove low in the preceding sample phase. Otherwise `drv_en`=0.
- R6: In every turn-around phase, `drv_en` is 0. The block never drives low for two clocks in a row.
- R7: The Stop Frame is measured only after the last data frame. A low pulse exactly 2 clocks wide there selects quiet mode, and the mode takes effect in the clock in which the line returns high.
- R8: A Stop Frame 3 clocks wide selects continuous mode. Any other width leaves the mode unchanged.
- R9: In quiet mode, while idle with the line high, the block drives low for exactly one clock when `irq_req` differs from the value it last reported in its sample phase. The earliest such clock is the second clock after the line returns high at the end of the Stop Frame.
- R10: In continuous mode, the block never drives while idle, whatever `irq_req` does.
- R11: An idle low pulse shorter than START_MIN clocks does not start frame counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| line_in | input | 1 | Sampled level of the shared line |
| irq_req | input | 1 | Local interrupt request, 1 = requesting |
| slot_sel | input | SLOT_W | Frame number assigned to this device |
| slot_act_low | input | 1 | 1 = active-low slot polarity, 0 = active-high |
| drv_en | output | 1 | Output enable of the open-drain pad |
| drv_val | output | 1 | Level driven while `drv_en` is high |

## Verification
The assertions assume that `slot_sel` and `slot_act_low` do not change while data frames are running. They also assume that `irq_req` is stable across each sample phase, so that the recovery drive matches the low drive before it. The stimulus changes these inputs only while the bus is idle, before the Start Frame opens. It models the line as a wired-AND of the host and the block. The host's Stop Frame always begins after the block has finished its last frame.

// File: rtl/serirq_slot.sv
module serirq_slot #(
  parameter int NUM_FRAMES = 21,
  parameter int START_MIN  = 4,
  parameter int SLOT_W     = $clog2(NUM_FRAMES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_in,
  input  logic              irq_req,
  input  logic [SLOT_W-1:0] slot_sel,
  input  logic              slot_act_low,
  output logic              drv_en,
  output logic              drv_val
);

  localparam int CNT_MAX = (START_MIN > 4) ? START_MIN : 4;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [SLOT_W-1:0] LAST_FR = SLOT_W'(NUM_FRAMES - 1);

  localparam logic [1:0] ST_IDLE = 2'd0;
  localparam logic [1:0] ST_DATA = 2'd1;
  localparam logic [1:0] ST_STOP = 2'd2;

  localparam logic [1:0] PH_SMP  = 2'd0;
  localparam logic [1:0] PH_REC  = 2'd1;
  localparam logic [1:0] PH_TRN  = 2'd2;

  logic [1:0]        st, ph;
  logic [SLOT_W-1:0] frame;
  logic [CNT_W-1:0]  lowcnt;
  logic              quiet_q, rep_q, drove_low, start_q;

  logic own, want_low, low_end;

  assign own      = (st == ST_DATA) && (frame == slot_sel);
  assign want_low = slot_act_low ? irq_req : ~irq_req;
  assign low_end  = line_in && (lowcnt != '0);

  assign drv_en  = start_q | (own & (((ph == PH_SMP) & want_low) |
                                     ((ph == PH_REC) & drove_low)));
  assign drv_val = (st == ST_DATA) && (ph == PH_REC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lowcnt <= '0;
    else if (line_in || st == ST_DATA)
      lowcnt <= '0;
    else if (lowcnt != CNT_W'(CNT_MAX))
      lowcnt <= lowcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      ph        <= PH_SMP;
      frame     <= '0;
      quiet_q   <= 1'b0;
      rep_q     <= 1'b0;
      drove_low <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (low_end && lowcnt >= CNT_W'(START_MIN)) begin
            st    <= ST_DATA;
            ph    <= PH_SMP;
            frame <= '0;
          end
        end
        ST_DATA: begin
          case (ph)
            PH_SMP: begin
              ph <= PH_REC;
              if (own) begin
                drove_low <= want_low;
                rep_q     <= irq_req;
              end
            end
            PH_REC: ph <= PH_TRN;
            default: begin
              drove_low <= 1'b0;
              ph        <= PH_SMP;
              if (frame == LAST_FR)
                st <= ST_STOP;
              else
                frame <= frame + 1'b1;
            end
          endcase
        end
        ST_STOP: begin
          if (low_end) begin
            st <= ST_IDLE;
            if (lowcnt == CNT_W'(2))
              quiet_q <= 1'b1;
            else if (lowcnt == CNT_W'(3))
              quiet_q <= 1'b0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      start_q <= 1'b0;
    else
      start_q <= (st == ST_IDLE) && quiet_q && line_in && (lowcnt == '0) &&
                 !start_q && (irq_req != rep_q);
  end

endmodule

// File: rtl/serirq_slot_chk.sv
module serirq_slot_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       drv_en,
  input logic       drv_val,
  input logic [1:0] st,
  input logic [1:0] ph,
  input logic       quiet_q
);

  AST_RESET_RELEASES: assert property (@(posedge clk) !rst_n |=> !drv_en); // R1

  AST_RECOV_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en && drv_val) |-> $past(drv_en && !drv_val)); // R5

  AST_LOW_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en && !drv_val) |=> !(drv_en && !drv_val)); // R6

  AST_TURN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && ph == 2'd2) |-> !drv_en); // R6

  AST_CONT_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && !quiet_q) |-> !drv_en); // R10

  AST_MODE_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_q != $past(quiet_q)) |-> $past(st == 2'd2)); // R7

endmodule

bind serirq_slot serirq_slot_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .drv_en  (drv_en),
  .drv_val (drv_val),
  .st      (st),
  .ph      (ph),
  .quiet_q (quiet_q)
);

// File: tb/tb_serirq_slot.sv
module tb_serirq_slot;

  localparam int CLK_PERIOD = 10;
  localparam int NF = 21;
  localparam int SW = 5;

  typedef struct {
    int    cyc;
    logic  en;
    logic  val;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_low = 1'b0;
  logic irq_req = 1'b0;
  logic [SW-1:0] slot_sel = '0;
  logic slot_act_low = 1'b0;
  logic line_in, drv_en, drv_val;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  exp_t q[$];
  exp_t it;

  assign line_in = ~(host_low | (drv_en & ~drv_val));

  serirq_slot dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .irq_req(irq_req),
    .slot_sel(slot_sel), .slot_act_low(slot_act_low),
    .drv_en(drv_en), .drv_val(drv_val)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      it = q.pop_front();
      checks++;
      if (it.cyc != cyc || drv_en !== it.en || (it.en && drv_val !== it.val)) begin
        errors++;
        $display("FAIL %s cycle %0d: drv_en=%b drv_val=%b expected en=%b val=%b",
                 it.tag, it.cyc, drv_en, drv_val, it.en, it.val);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic push(input int c, input logic en, input logic val, input string tag);
    exp_t e;
    e.cyc = c; e.en = en; e.val = val; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle_quiet(input int n, input string tag);
    for (int i = 1; i <= n; i++) push(cyc + i, 1'b0, 1'b0, tag);
    repeat (n) step();
  endtask

  task automatic run_cycle(input logic [SW-1:0] slot, input logic act_low,
                           input logic req, input int stop_w);
    int c0;
    logic wl;
    string ptag;
    slot_sel = slot; slot_act_low = act_low; irq_req = req;
    wl = act_low ? req : ~req;
    ptag = act_low ? "R4" : "R3";
    host_low = 1'b1;
    repeat (4) step();
    host_low = 1'b0;
    c0 = cyc;
    for (int n = 0; n < NF; n++) begin
      logic mine;
      mine = (int'(slot) == n);
      push(c0 + 1 + 3*n, mine && wl, 1'b0, mine ? ptag : "R2");
      push(c0 + 2 + 3*n, mine && wl, 1'b1, "R5");
      push(c0 + 3 + 3*n, 1'b0, 1'b0, "R6");
    end
    while (cyc < c0 + 3*NF + 1) step();
    host_low = 1'b1;
    repeat (stop_w) step();
    host_low = 1'b0;
    step();
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    irq_req = 1'b1;
    idle_quiet(6, "R1");

    run_cycle(5'd3, 1'b0, 1'b0, 3);
    run_cycle(5'd3, 1'b0, 1'b1, 2);

    irq_req = 1'b0;
    push(cyc + 1, 1'b1, 1'b0, "R9");
    push(cyc + 2, 1'b0, 1'b0, "R9");
    step();
    run_cycle(5'd5, 1'b1, 1'b0, 4);

    irq_req = 1'b1;
    push(cyc + 1, 1'b1, 1'b0, "R8");
    push(cyc + 2, 1'b0, 1'b0, "R8");
    step();
    run_cycle(5'd5, 1'b1, 1'b1, 3);

    irq_req = 1'b0;
    idle_quiet(8, "R10");

    slot_sel = 5'd0; slot_act_low = 1'b0; irq_req = 1'b0;
    host_low = 1'b1;
    repeat (2) step();
    host_low = 1'b0;
    idle_quiet(10, "R11");

    run_cycle(5'd25, 1'b0, 1'b1, 2);
    idle_quiet(4, "R7");
    run_cycle(5'(NF - 1), 1'b1, 1'b1, 3);
    idle_quiet(4, "R10");

    repeat (3) step();
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R2: %0d expected items never observed, expected 0", q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, actual 20000 cycles, expected fewer");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule